// File: doc/BRIEF.md
# Flyback PWM Timing Generator

This block produces the gate-drive pulse of a fixed-frequency, voltage-mode switching converter. An internal cycle counter divides the system clock into switching periods. At the first count of every period a clock pulse sets a reset-dominant latch that drives the gate. The pulse ends when the first of three things happens: the PWM comparator asks for turn-off, the overcurrent comparator trips, or the on-time reaches 70% of the period.

Overcurrent is only heeded after a short leading-edge blanking interval that follows each turn-on. It ends conduction for the current period only. A period that ended on overcurrent is reported by a single-clock flag. A standby select picks a longer period for light-load operation: 22 kHz instead of 65 kHz. A change of the select is applied at the next period boundary, so no period is ever cut short. With the enable low the gate is forced off and the counter waits at the start of a period.

Top module: `pwm_timing_gen`

## Requirements
- R1: While reset is applied, and until the first period starts after its release, gate_o and oc_flag_o are 0.
- R2: In normal mode (sb_sel_i = 0), consecutive gate turn-ons with nothing ending the pulse early are PER_NORM clocks apart.
- R3: In standby mode (sb_sel_i = 1), consecutive turn-ons are PER_STBY clocks apart.
- R4: Gate turn-on follows the clock edge that starts a period, and the pulse lasts at most floor(PER*ON_NUM/ON_DEN) clocks of the active period PER (14 for a 20-clock period, 25 for a 37-clock period).
- R5: pwm_off_i = 1 sampled at an edge during a pulse drives gate_o low after that edge. If it is 1 at the edge that starts a period, that period has no pulse, because reset wins over set.
- R6: oc_i = 1 sampled after blanking ends the pulse after that edge. The next period turns on again as normal.
- R7: oc_i is ignored during the first BLANK clocks that the gate is high, and while the gate is low. The pulse then lasts its full length.
- R8: oc_flag_o is a one-clock pulse. It is high in the clock where gate_o first reads low after a turn-off caused by a valid overcurrent, and it is 0 at every other time.
- R9: sb_sel_i is sampled only at the last count of a period, or while the block is disabled. A change at any other time has no effect on the period in progress.
- R10: en_i = 0 sampled at an edge drives gate_o low after that edge and holds it low. The first edge with en_i = 1 after that starts a new period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_i | input | 1 | Enable; low forces the gate off and restarts the period counter |
| sb_sel_i | input | 1 | Period select: 0 normal, 1 standby |
| pwm_off_i | input | 1 | PWM comparator flag, 1 requests turn-off |
| oc_i | input | 1 | Overcurrent comparator flag, 1 means current above limit |
| gate_o | output | 1 | Gate-drive pulse |
| oc_flag_o | output | 1 | One-clock pulse marking a period ended by overcurrent |

## Verification
Two pairs of functions can fall in the same clock. The first is the period-start set meeting a turn-off request from the PWM comparator. The second is an overcurrent trip meeting the end of the duty window. Both are provoked by sweeping the clock at which the comparator flag is asserted over every count of the period, in both modes. The sweep includes count 0, which must give a skipped period, and the duty-limit count, where the pulse length stays the same but the flag must still appear. Each sample of the gate and the flag is judged against a pulse length and a flag position computed from the period, duty ratio and blanking length.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  typedef enum logic {
    MODE_NORM = 1'b0,
    MODE_STBY = 1'b1
  } pwm_mode_e;

  // on-time limit in clocks for a period of per clocks
  function automatic int unsigned on_limit(int unsigned per, int unsigned num, int unsigned den);
    return (per * num) / den;
  endfunction

endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[s] <= 1'b0;
        else         sync_q[s] <= 1'b1;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[s] <= 1'b0;
        else         sync_q[s] <= sync_q[s-1];
      end
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/pwm_period_gen.sv
module pwm_period_gen
  import pwm_pkg::*;
#(
  parameter int unsigned PER_NORM = 200,
  parameter int unsigned PER_STBY = 591,
  parameter int unsigned ON_NUM   = 7,
  parameter int unsigned ON_DEN   = 10,
  parameter int unsigned CW       = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          sb_sel_i,
  output logic [CW-1:0] cnt_o,
  output logic          start_o,
  output logic [CW-1:0] max_on_o
);

  localparam logic [CW-1:0] LAST_NORM = CW'(PER_NORM - 1);
  localparam logic [CW-1:0] LAST_STBY = CW'(PER_STBY - 1);
  localparam logic [CW-1:0] MAXON_NORM = CW'(on_limit(PER_NORM, ON_NUM, ON_DEN));
  localparam logic [CW-1:0] MAXON_STBY = CW'(on_limit(PER_STBY, ON_NUM, ON_DEN));

  logic [CW-1:0] cnt_q, cnt_d;
  pwm_mode_e     mode_q, mode_d;
  logic          mode_ce;
  logic [CW-1:0] last_cur;
  logic          wrap;

  always_comb begin
    last_cur = (mode_q == MODE_STBY) ? LAST_STBY : LAST_NORM;
    wrap     = (cnt_q == last_cur);
    mode_ce  = !en_i || wrap;
    mode_d   = sb_sel_i ? MODE_STBY : MODE_NORM;
    if (!en_i || wrap) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mode_q <= MODE_NORM;
    end else begin
      cnt_q <= cnt_d;
      if (mode_ce) mode_q <= mode_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign start_o  = en_i && (cnt_q == '0);
  assign max_on_o = (mode_q == MODE_STBY) ? MAXON_STBY : MAXON_NORM;

  // R2, R3: counter stays inside the active period
  p_cnt_in_period_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last_cur);

  // R9: the mode only moves at a period boundary or while disabled
  p_mode_at_boundary_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_q) |-> (!$past(en_i) || ($past(cnt_q) == ((($past(mode_q)) == MODE_STBY) ? LAST_STBY : LAST_NORM))));

endmodule

// File: rtl/pwm_blank_win.sv
module pwm_blank_win #(
  parameter int unsigned BLANK = 2,
  parameter int unsigned BW    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_i,
  input  logic oc_i,
  output logic oc_hit_o
);

  localparam logic [BW-1:0] BLANK_V = BW'(BLANK);

  logic [BW-1:0] blk_q, blk_d;
  logic          blk_ce;
  logic          open_win;

  always_comb begin
    open_win = gate_i && (blk_q == BLANK_V);
    blk_ce   = !gate_i || (blk_q != BLANK_V);
    if (!gate_i) blk_d = '0;
    else         blk_d = blk_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     blk_q <= '0;
    else if (blk_ce) blk_q <= blk_d;
  end

  assign oc_hit_o = open_win && oc_i;

  // R7: the blanking count never runs past its limit
  p_blank_bounded_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_q <= BLANK_V);

endmodule

// File: rtl/pwm_gate_latch.sv
module pwm_gate_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic set_i,
  input  logic clr_pwm_i,
  input  logic clr_oc_i,
  input  logic clr_duty_i,
  output logic gate_o,
  output logic oc_flag_o
);

  logic gate_q, gate_d;
  logic flag_q, flag_d;
  logic clr_any;

  always_comb begin
    clr_any = !en_i || clr_pwm_i || clr_oc_i || clr_duty_i;
    gate_d  = !clr_any && (set_i || gate_q);
    flag_d  = en_i && clr_oc_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      gate_q <= gate_d;
      flag_q <= flag_d;
    end
  end

  assign gate_o    = gate_q;
  assign oc_flag_o = flag_q;

  // R5: a turn-off request wins over a simultaneous set
  p_reset_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && clr_pwm_i) |=> !gate_q);

  // R8: the flag lasts one clock
  p_flag_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q |=> !flag_q);

endmodule

// File: rtl/pwm_timing_gen.sv
module pwm_timing_gen
  import pwm_pkg::*;
#(
  parameter int unsigned PER_NORM = 200,
  parameter int unsigned PER_STBY = 591,
  parameter int unsigned BLANK    = 2,
  parameter int unsigned ON_NUM   = 7,
  parameter int unsigned ON_DEN   = 10,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic sb_sel_i,
  input  logic pwm_off_i,
  input  logic oc_i,
  output logic gate_o,
  output logic oc_flag_o
);

  localparam int unsigned PMAX = (PER_NORM > PER_STBY) ? PER_NORM : PER_STBY;
  localparam int unsigned CW   = $clog2(PMAX + 1);
  localparam int unsigned BW   = (BLANK > 0) ? $clog2(BLANK + 1) : 1;

  logic          rst_n;
  logic [CW-1:0] cnt;
  logic [CW-1:0] max_on;
  logic          start;
  logic          duty_end;
  logic          oc_hit;
  logic          gate;
  logic          flag;

  pwm_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  pwm_period_gen #(
    .PER_NORM (PER_NORM),
    .PER_STBY (PER_STBY),
    .ON_NUM   (ON_NUM),
    .ON_DEN   (ON_DEN),
    .CW       (CW)
  ) u_period (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .en_i     (en_i),
    .sb_sel_i (sb_sel_i),
    .cnt_o    (cnt),
    .start_o  (start),
    .max_on_o (max_on)
  );

  assign duty_end = (cnt >= max_on);

  pwm_blank_win #(.BLANK(BLANK), .BW(BW)) u_blank (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .gate_i   (gate),
    .oc_i     (oc_i),
    .oc_hit_o (oc_hit)
  );

  pwm_gate_latch u_latch (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .en_i       (en_i),
    .set_i      (start),
    .clr_pwm_i  (pwm_off_i),
    .clr_oc_i   (oc_hit),
    .clr_duty_i (duty_end),
    .gate_o     (gate),
    .oc_flag_o  (flag)
  );

  assign gate_o    = gate;
  assign oc_flag_o = flag;

  // R4: turn-on only follows a period start
  p_rise_at_start_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(gate) |-> $past(start));

  // R4: a high gate lies inside the duty window of the period
  p_on_window_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    gate |-> ((cnt >= CW'(1)) && (cnt <= max_on)));

  // R8: the flag marks the clock of an overcurrent turn-off
  p_flag_at_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    flag |-> (!gate && $past(gate) && $past(oc_i)));

  // R10: disable forces the gate off
  p_disable_off_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    !en_i |=> !gate);

  // R1: nothing is driven during reset
  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_n |-> (!gate && !flag));

endmodule

// File: tb/pwm_timing_gen_tb_top.sv
`timescale 1ns/1ps
module pwm_timing_gen_tb_top;

  localparam int PN = 20;
  localparam int PS = 37;
  localparam int BL = 2;
  localparam int ON_N = (PN * 7) / 10;
  localparam int ON_S = (PS * 7) / 10;

  logic clk = 1'b0;
  logic rst_n, en, sb, poff, oc;
  logic gate, flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwm_timing_gen #(
    .PER_NORM (PN),
    .PER_STBY (PS),
    .BLANK    (BL),
    .ON_NUM   (7),
    .ON_DEN   (10),
    .SYNC_STG (2)
  ) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .en_i      (en),
    .sb_sel_i  (sb),
    .pwm_off_i (poff),
    .oc_i      (oc),
    .gate_o    (gate),
    .oc_flag_o (flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // kind 0: pwm_off from count k on; kind 1: one-clock overcurrent at count k
  task automatic trial(input int mode, input int kind, input int k);
    int per, mon, width, fpos;
    per = mode ? PS : PN;
    mon = mode ? ON_S : ON_N;
    if (kind == 0) begin
      width = (k < mon) ? k : mon;
      fpos  = -1;
    end else if (k >= BL + 1 && k <= mon) begin
      width = k;
      fpos  = k;
    end else begin
      width = mon;
      fpos  = -1;
    end
    en = 1'b0; poff = 1'b0; oc = 1'b0; sb = mode[0];
    repeat (2) @(negedge clk);
    chk("R10 idle gate", int'(gate), 0);
    en   = 1'b1;
    poff = (kind == 0) && (k == 0);
    oc   = (kind == 1) && (k == 0);
    for (int j = 0; j < per - 1; j++) begin
      @(negedge clk);
      if (kind == 0) chk("R5 R4 gate vs pwm_off sweep", int'(gate), int'(j < width));
      else           chk("R6 R7 gate vs overcurrent sweep", int'(gate), int'(j < width));
      chk("R8 flag position", int'(flag), int'(j == fpos));
      poff = (kind == 0) && (j + 1 >= k);
      oc   = (kind == 1) && (j + 1 == k);
    end
    poff = 1'b0; oc = 1'b0;
  endtask

  initial begin
    int exp_rise[6] = '{0, 20, 40, 77, 114, 134};
    int nr;
    int prev;
    rst_n = 1'b0; en = 1'b0; sb = 1'b0; poff = 1'b0; oc = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 gate in reset", int'(gate), 0);
    chk("R1 flag in reset", int'(flag), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 gate after release", int'(gate), 0);
    chk("R1 flag after release", int'(flag), 0);

    for (int m = 0; m < 2; m++)
      for (int kd = 0; kd < 2; kd++)
        for (int k = 0; k < (m ? PS : PN); k++)
          trial(m, kd, k);

    // R2 R3 R9: turn-on spacing with select changes
    en = 1'b0; sb = 1'b0;
    repeat (2) @(negedge clk);
    en = 1'b1;
    nr = 0; prev = 0;
    for (int s = 0; s < 150; s++) begin
      @(negedge clk);
      if (gate && !prev) begin
        if (nr < 6) chk("R2 R3 R9 turn-on clock", s, exp_rise[nr]);
        nr++;
      end
      prev = int'(gate);
      if (s == 10) sb = 1'b1;
      if (s == 11) sb = 1'b0;
      if (s == 25) sb = 1'b1;
      if (s == 80) sb = 1'b0;
    end
    chk("R2 R3 turn-on count", nr, 6);

    // R10: disable mid-pulse, then restart
    en = 1'b0; sb = 1'b0;
    repeat (2) @(negedge clk);
    en = 1'b1;
    for (int s = 0; s < 12; s++) begin
      @(negedge clk);
      if (s == 5) chk("R10 gate before disable", int'(gate), 1);
      if (s >= 6 && s <= 9) chk("R10 gate held low", int'(gate), 0);
      if (s == 10) chk("R10 restart turn-on", int'(gate), 1);
      if (s == 5) en = 1'b0;
      if (s == 9) en = 1'b1;
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule